// File: doc/BRIEF.md
# Keyed Integer Clock Divider Manager

This block derives a slower clock for a pulse-width modulator from a fast source clock by whole-number division. Software controls it through two 32-bit registers. The control register sits at byte offset 0x00 and selects the source and the enable. The divisor register sits at byte offset 0x04 and holds the integer divisor. A write lands only if its top byte carries the key value 0x5A. Any other write is dropped.

To start the clock, software selects source 6 (the fast source) and sets the enable. It then polls a busy flag until the divided clock is confirmed as running. To stop the clock, it clears the enable and polls until busy reads 0. While the clock runs, the source and divisor are locked, and only the enable can be changed. The block drives a divided clock level and a one-cycle clock-enable strobe. Both are expressed in source-clock cycles for the downstream modulator.

The sequencer has four states:
- IDLE: the counter is held at zero.
- START: the counter is running, but the first divided edge has not yet occurred.
- RUN: busy is 1.
- DRAIN: the enable has been cleared, and the current output period is being finished.

It has these transitions:
- IDLE→START when the enable is set and the source is 6.
- START→IDLE if the enable drops or the source is not 6.
- START→RUN at the end of the first period.
- RUN→DRAIN when the enable clears mid-period.
- RUN→IDLE when the enable clears on the last cycle of a period.
- DRAIN→IDLE at the end of the period.

Top module: `clkdiv_mgr`

## Requirements
- R1: After reset, both registers read 0, busy is 0, and `div_clk` and `div_tick` are 0.
- R2: A write whose bits 31:24 differ from 0x5A leaves both registers unchanged.
- R3: Reads of the registers return the following, with every other bit 0 (including bits 31:24):
  - Offset 0x00 returns the source in bits 3:0, the enable in bit 4 and busy in bit 7.
  - Offset 0x04 returns the stored divisor in bits 23:12.
- R4: After a keyed write that sets enable with source 6 and divisor D, busy and `div_clk` rise D+1 source cycles after the write edge, at the first divided edge.
- R5: While busy, `div_tick` is high for exactly one source cycle in every D, namely the last cycle of each output period.
- R6: A divisor write while busy is 1 is ignored.
- R7: A control write while busy is 1 leaves the source unchanged, but its enable bit still takes effect.
- R8: When the enable is cleared while busy, busy stays 1 until the current output period ends. It then falls, with no further `div_clk` high phase.
- R9: A stored divisor below 4 behaves as 4, while the read value keeps the stored number.
- R10: With the enable set and a source other than 6 (ground), busy never rises and `div_clk` stays 0.
- R11: While busy, `div_clk` is high for the first floor(D/2) source cycles of each D-cycle period and low for the rest.
- R12: Clearing the enable before the first divided edge returns the block to idle without any `div_clk` high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset: 0x0 control, 0x4 divisor |
| reg_wdata | input | 32 | Write data, key in bits 31:24 |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| div_clk | output | 1 | Divided clock level |
| div_tick | output | 1 | One-cycle enable in the last source cycle of each divided period |

## Verification
The bench builds the block with its default parameters:
- a 12-bit divisor;
- fast source code 6;
- minimum divisor 4;
- key 0x5A.

These defaults bring within reach both the smallest legal period, including the clamp from a stored value of 2, and the largest period of 4095 cycles. A behavioural model follows every source cycle, so the start latency, the one-period drain and the locking of source and divisor during the run are compared edge by edge. Odd and even divisors cover the floor rule for the high phase.

// File: rtl/clkdiv_mgr_pkg.sv
package clkdiv_mgr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } cdm_state_e;

endpackage

// File: rtl/cdm_regs.sv
module cdm_regs #(
    parameter int          REG_W    = 32,
    parameter int          ADDR_W   = 3,
    parameter int          DIV_W    = 12,
    parameter int          SRC_W    = 4,
    parameter logic [7:0]  PASSWORD = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    output logic [SRC_W-1:0]  src_q,
    output logic              en_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int KEY_MSB  = REG_W - 1;
    localparam int EN_BIT   = SRC_W;
    localparam int BUSY_BIT = EN_BIT + 3;
    localparam int DIV_LSB  = 12;
    localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DIV_OFF  = ADDR_W'(4);

    logic key_ok;
    logic wr_ctrl;
    logic wr_div;
    logic wdata_unused;

    assign key_ok       = (reg_wdata[KEY_MSB -: 8] == PASSWORD);
    assign wr_ctrl      = reg_wr && key_ok && (reg_addr == CTRL_OFF);
    assign wr_div       = reg_wr && key_ok && (reg_addr == DIV_OFF);
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            en_q  <= 1'b0;
            div_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= reg_wdata[EN_BIT];
                if (!busy) begin
                    src_q <= reg_wdata[SRC_W-1:0];
                end
            end
            if (wr_div && !busy) begin
                div_q <= reg_wdata[DIV_LSB +: DIV_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFF) begin
            reg_rdata[SRC_W-1:0] = src_q;
            reg_rdata[EN_BIT]    = en_q;
            reg_rdata[BUSY_BIT]  = busy;
        end else if (reg_addr == DIV_OFF) begin
            reg_rdata[DIV_LSB +: DIV_W] = div_q;
        end
    end

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !key_ok) |=> ($stable(src_q) && $stable(en_q) && $stable(div_q))); // R2
    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_q)); // R6
    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(src_q)); // R7

endmodule

// File: rtl/cdm_fsm.sv
module cdm_fsm
    import clkdiv_mgr_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int SRC_W    = 4,
    parameter int SRC_FAST = 6,
    parameter int DIV_MIN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SRC_W-1:0] src,
    input  logic [DIV_W-1:0] div_raw,
    output logic             busy,
    output logic             div_clk,
    output logic             div_tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(DIV_MIN);
    localparam logic [SRC_W-1:0] FAST    = SRC_W'(SRC_FAST);

    cdm_state_e       state, nxt;
    logic [DIV_W-1:0] cnt, cnt_nxt;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half;
    logic             last;
    logic             go;

    assign div_eff = (div_raw < MIN_DIV) ? MIN_DIV : div_raw;
    assign half    = div_eff >> 1;
    assign last    = (cnt >= div_eff - DIV_W'(1));
    assign go      = en && (src == FAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = ST_START;
            ST_START: begin
                if (!go)       nxt = ST_IDLE;
                else if (last) nxt = ST_RUN;
            end
            ST_RUN:   if (!en) nxt = last ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (last) nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        if (state == ST_IDLE || last || nxt == ST_IDLE) cnt_nxt = '0;
        else                                            cnt_nxt = cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        busy     = (state == ST_RUN) || (state == ST_DRAIN);
        div_clk  = busy && (cnt < half);
        div_tick = busy && last;
    end

    AST_BUSY_AFTER_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state) == ST_START && cnt == '0)); // R4
    AST_STOP_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(last)); // R8
    AST_GROUND_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((src != FAST) && !busy) |=> !busy); // R10
    AST_TICK_ONE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick); // R5

endmodule

// File: rtl/clkdiv_mgr.sv
module clkdiv_mgr #(
    parameter int          REG_W    = 32,
    parameter int          ADDR_W   = 3,
    parameter int          DIV_W    = 12,
    parameter int          SRC_W    = 4,
    parameter int          SRC_FAST = 6,
    parameter int          DIV_MIN  = 4,
    parameter logic [7:0]  PASSWORD = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              div_clk,
    output logic              div_tick
);
    logic             busy;
    logic             en_q;
    logic [SRC_W-1:0] src_q;
    logic [DIV_W-1:0] div_q;

    cdm_regs #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
        .SRC_W(SRC_W), .PASSWORD(PASSWORD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .src_q(src_q), .en_q(en_q),
        .div_q(div_q), .reg_rdata(reg_rdata)
    );

    cdm_fsm #(
        .DIV_W(DIV_W), .SRC_W(SRC_W), .SRC_FAST(SRC_FAST), .DIV_MIN(DIV_MIN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .src(src_q), .div_raw(div_q),
        .busy(busy), .div_clk(div_clk), .div_tick(div_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!div_clk && !div_tick && !busy)); // R1

endmodule

// File: tb/test_clkdiv_mgr.sv
`timescale 1ns/1ps
module test_clkdiv_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        div_clk;
    logic        div_tick;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    clkdiv_mgr i_clkdiv_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .div_clk(div_clk), .div_tick(div_tick)
    );

    // behavioural reference model
    int m_src = 0, m_en = 0, m_div = 0, m_st = 0, m_cnt = 0;

    always @(posedge clk) begin
        int d; int ns; int nc; bit last; bit bsy;
        if (!rst_n) begin
            m_src = 0; m_en = 0; m_div = 0; m_st = 0; m_cnt = 0;
        end else begin
            d    = (m_div < 4) ? 4 : m_div;
            bsy  = (m_st >= 2);
            last = (m_cnt >= d - 1);
            ns   = m_st;
            if (m_st == 0) begin
                if (m_en == 1 && m_src == 6) ns = 1;
            end else if (m_st == 1) begin
                if (!(m_en == 1 && m_src == 6)) ns = 0;
                else if (last) ns = 2;
            end else if (m_st == 2) begin
                if (m_en == 0) ns = last ? 0 : 3;
            end else begin
                if (last) ns = 0;
            end
            nc = (m_st == 0 || last || ns == 0) ? 0 : m_cnt + 1;
            if (reg_wr && reg_wdata[31:24] == 8'h5A) begin
                if (reg_addr == 3'd0) begin
                    m_en = reg_wdata[4];
                    if (!bsy) m_src = reg_wdata[3:0];
                end else if (reg_addr == 3'd4 && !bsy) begin
                    m_div = reg_wdata[23:12];
                end
            end
            m_st = ns; m_cnt = nc;
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        logic [31:0] r = 32'd0;
        if (a == 3'd0) begin
            r[3:0] = m_src[3:0]; r[4] = m_en[0]; r[7] = (m_st >= 2);
        end else if (a == 3'd4) begin
            r[23:12] = m_div[11:0];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // per-cycle comparison
    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            int d; bit b;
            d = (m_div < 4) ? 4 : m_div;
            b = (m_st >= 2);
            chk("R4/R11 div_clk cycle", {31'd0, div_clk}, {31'd0, b && (m_cnt < d / 2)});
            chk("R5 div_tick cycle", {31'd0, div_tick}, {31'd0, b && (m_cnt >= d - 1)});
            chk("R3 rdata cycle", reg_rdata, exp_rdata(reg_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    // counts source cycles from now until busy (div_clk) first rises
    task automatic wait_rise(output int n);
        n = 0;
        while (!div_clk) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic measure_period(output int per, output int hi);
        while (!div_tick) begin @(posedge clk); #1; end
        per = 0; hi = 0;
        do begin
            @(posedge clk); #1; per++;
            if (div_clk) hi++;
        end while (!div_tick);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n; int per; int hi; int seen;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cmp_en = 1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl after reset", v, 32'd0);
        rd(3'd4, v); chk("R1 div after reset", v, 32'd0);
        chk("R1 div_clk after reset", {31'd0, div_clk}, 32'd0);

        // R3 divisor readback, R2 bad key
        wr(3'd4, 32'h5A000000 | (32'd5 << 12));
        rd(3'd4, v); chk("R3 divisor readback", v, 32'd5 << 12);
        wr(3'd4, 32'h5B000000 | (32'd9 << 12));
        rd(3'd4, v); chk("R2 divisor bad key", v, 32'd5 << 12);
        wr(3'd0, 32'h00000016);
        rd(3'd0, v); chk("R2 control bad key", v, 32'd0);

        // R4 start latency, D=5
        wr(3'd0, 32'h5A000016);
        wait_rise(n); chk("R4 start latency D=5", n, 32'd6);
        rd(3'd0, v); chk("R3 control running", v, 32'h96);
        measure_period(per, hi);
        chk("R5 period D=5", per, 32'd5);
        chk("R11 high time D=5", hi, 32'd2);

        // R6 and R7 locked while running
        wr(3'd4, 32'h5A000000 | (32'd8 << 12));
        rd(3'd4, v); chk("R6 divisor locked", v, 32'd5 << 12);
        wr(3'd0, 32'h5A000011);
        rd(3'd0, v); chk("R7 source locked", v, 32'h96);
        measure_period(per, hi);
        chk("R7 still running D=5", per, 32'd5);

        // R8 stop drains current period
        wr(3'd0, 32'h5A000006);
        rd(3'd0, v); chk("R8 busy held after stop", v, 32'h86);
        n = 0;
        while (reg_rdata[7]) begin @(posedge clk); #1; n++; end
        chk("R8 busy falls within a period", {31'd0, (n >= 1 && n <= 6)}, 32'd1);
        repeat (10) @(posedge clk);
        #1; chk("R8 output quiet after stop", {31'd0, div_clk}, 32'd0);

        // R9 clamp
        wr(3'd4, 32'h5A000000 | (32'd2 << 12));
        rd(3'd4, v); chk("R9 raw divisor kept", v, 32'd2 << 12);
        wr(3'd0, 32'h5A000016);
        wait_rise(n); chk("R9 start latency clamped", n, 32'd5);
        measure_period(per, hi);
        chk("R9 clamped period", per, 32'd4);
        chk("R11 high time D=4", hi, 32'd2);
        wr(3'd0, 32'h5A000006);
        repeat (10) @(negedge clk);

        // R10 ground source
        wr(3'd0, 32'h5A000010);
        seen = 0;
        repeat (40) begin @(posedge clk); #1; if (div_clk || div_tick) seen++; end
        rd(3'd0, v); chk("R10 ground never busy", v, 32'h10);
        chk("R10 no output on ground", seen, 32'd0);
        wr(3'd0, 32'h5A000000);

        // R12 abort before first edge
        wr(3'd4, 32'h5A000000 | (32'd20 << 12));
        wr(3'd0, 32'h5A000016);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'h5A000006);
        seen = 0;
        repeat (40) begin @(posedge clk); #1; if (div_clk) seen++; end
        chk("R12 abort before edge", seen, 32'd0);

        // R11 odd divisor
        wr(3'd4, 32'h5A000000 | (32'd7 << 12));
        wr(3'd0, 32'h5A000016);
        measure_period(per, hi);
        chk("R11 period D=7", per, 32'd7);
        chk("R11 high time D=7", hi, 32'd3);
        wr(3'd0, 32'h5A000006);
        repeat (12) @(negedge clk);

        // R4 largest divisor
        wr(3'd4, 32'h5A000000 | (32'd4095 << 12));
        wr(3'd0, 32'h5A000016);
        wait_rise(n); chk("R4 start latency D=4095", n, 32'd4096);
        wr(3'd0, 32'h5A000006);
        n = 0;
        while (reg_rdata[7]) begin @(posedge clk); #1; n++; end
        chk("R8 drain D=4095 bounded", {31'd0, (n >= 1 && n <= 4096)}, 32'd1);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule